// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Replay

This block is a first-in first-out buffer whose write side and read side each run on their own clock. The two clocks have no fixed relation: either may be fast, slow or stopped while the other runs. Read and write positions cross between the two clock domains as Gray-coded counters through two-stage synchronizers. The full condition and the half-full condition are judged on the write side. The empty condition is judged on the read side.

The read side has two timing modes, chosen while master reset is held. In standard mode a word reaches the output register only when a read is requested. In fall-through mode the oldest stored word is moved to the output by itself, and a read request consumes it. The two status outputs change meaning with the mode, from empty/full to output-ready/input-ready. Partial reset empties the buffer but keeps the chosen mode. A mark input saves the current read position, and a rewind input sends the read position back to it, so that a stretch of data can be sent again.

Top module: `twin_clock_fifo`

## Requirements
- R1: While `mrst` is high and for as long after its release as nothing is written, the buffer is empty. `rd_data` is 0 and `half_full` is 0. In standard mode `flag_ef_or`=1 and `flag_ff_ir`=0. In fall-through mode `flag_ef_or`=0 and `flag_ff_ir`=1.
- R2: `fwft_sel` is sampled only on clock edges while `mrst` is high, with 1 selecting fall-through mode and 0 selecting standard mode. Changes at any other time have no effect.
- R3: In standard mode `rd_data` changes only on a read-clock edge with `rd_en`=1 while stored data exists. It is held otherwise, including after the first write into an empty buffer.
- R4: In fall-through mode the first word written into an empty buffer appears on `rd_data` with `flag_ef_or`=1 on the third read-clock edge after the write becomes visible, without `rd_en`. It is held until a read-clock edge with `rd_en`=1 replaces it with the next word, or clears `flag_ef_or` if no word is stored.
- R5: In standard mode `flag_ef_or`=1 means no unread stored word and `flag_ff_ir`=1 means 2**AW words are stored. In fall-through mode `flag_ef_or`=1 means `rd_data` holds an unconsumed word and `flag_ff_ir`=1 means a write would be accepted. In fall-through mode the buffer holds 2**AW words in storage plus one in the output register.
- R6: `half_full`=1 exactly when the write side sees more than 2**(AW-1) words in storage, in either mode.
- R7: A write while storage is full and a read while nothing is stored are ignored: no word is lost, duplicated or invented, and `rd_data` is unchanged.
- R8: Words leave in the order in which they were accepted, and each write or read position moves by at most one Gray-code bit per clock.
- R9: A `prst` pulse empties the buffer and recomputes the flags as in R1 under the mode chosen at the last master reset. `fwft_sel` is not sampled during it.
- R10: `mark`=1 on a read-clock edge saves the read position, which is the location of the next word to be fetched from storage. `rewind`=1 on a read-clock edge loads the read position from the saved one. A read requested in that same cycle is ignored.
- R11: Both resets clear the saved position to the first location, so a rewind with no mark since the last reset restarts from the first word written after that reset.
- R12: After a rewind, emptiness, fullness and the half-full level are recomputed from the rewound read position, so that the replayed words can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | DW | Output register holding the last word fetched |
| mrst | input | 1 | Master reset, active high, asynchronous assert; both clocks must run while it is high |
| prst | input | 1 | Partial reset, active high, keeps the timing mode |
| fwft_sel | input | 1 | Timing-mode select captured during master reset |
| mark | input | 1 | Save the current read position, sampled on `rd_clk` |
| rewind | input | 1 | Restore the read position from the saved one, sampled on `rd_clk` |
| flag_ef_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| flag_ff_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than half of storage occupied, write-side view |

## Verification
The checker watches properties that hold on every cycle. The Gray-coded positions move by at most one bit per clock except on a rewind. The write-side level never exceeds the storage depth. Standard-mode output holds without a read, and a ready fall-through word holds until it is consumed. A rewind loads exactly the saved position, and the mode stays fixed outside master reset. The bench scenarios cover what a single-cycle property cannot show. It sweeps every fill level from empty to full and checks the flag meanings in both modes and the order and values of the data. It also checks that overflow and underflow attempts are ignored, that a partial reset keeps the mode, and that marked and unmarked rewinds replay the right words.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  // Binary to reflected Gray code.
  function automatic logic [31:0] b2g(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code to binary, by prefix XOR.
  function automatic logic [31:0] g2b(logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) begin
      b = b ^ (b >> s);
    end
    return b;
  endfunction

  // Occupancy between two pw-bit wrapping positions.
  function automatic logic [31:0] ptr_gap(logic [31:0] w, logic [31:0] r, int pw);
    return (w - r) & ((32'd1 << pw) - 32'd1);
  endfunction

  // Full when the Gray positions differ only in their two top bits.
  function automatic logic gray_full(logic [31:0] wg, logic [31:0] rg, int pw);
    logic [31:0] m;
    m = 32'd3 << (pw - 2);
    return wg == (rg ^ m);
  endfunction

endpackage

// File: rtl/tcf_sync2.sv
module tcf_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tcf_mem.sv
module tcf_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/tcf_wr_side.sv
module tcf_wr_side #(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mrst,
  input  logic        fwft_sel,
  input  logic        wr_en,
  input  logic [AW:0] rgray_sync,
  output logic [AW:0] wbin,
  output logic [AW:0] wgray,
  output logic [AW:0] level,
  output logic        push,
  output logic        flag_ff_ir,
  output logic        half_full
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  tcf_pkg::rd_mode_e mode_q;
  logic [AW:0] rbin_seen;
  logic [AW:0] wbin_nxt;
  logic        full;

  assign rbin_seen = PW'(tcf_pkg::g2b(32'(rgray_sync)));
  assign level     = PW'(tcf_pkg::ptr_gap(32'(wbin), 32'(rbin_seen), PW));
  assign full      = tcf_pkg::gray_full(32'(wgray), 32'(rgray_sync), PW);
  assign push      = wr_en && !full;
  assign wbin_nxt  = wbin + PW'(push);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= PW'(tcf_pkg::b2g(32'(wbin_nxt)));
    end
  end

  // Mode is captured on clock edges while master reset is held.
  always_ff @(posedge clk) begin
    if (mrst) mode_q <= tcf_pkg::rd_mode_e'(fwft_sel);
  end

  assign half_full  = level > PW'(DEPTH / 2);
  assign flag_ff_ir = (mode_q == tcf_pkg::MODE_FWFT) ? !full : full;
endmodule

// File: rtl/tcf_rd_side.sv
module tcf_rd_side #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mrst,
  input  logic          fwft_sel,
  input  logic          rd_en,
  input  logic          mark,
  input  logic          rewind,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [AW:0]   mark_ptr,
  output logic [DW-1:0] rd_data,
  output logic          flag_ef_or,
  output logic          fwft_q,
  output logic          pop
);
  localparam int PW = AW + 1;

  tcf_pkg::rd_mode_e mode_q;
  logic        mem_empty;
  logic        out_valid;
  logic [AW:0] rbin_nxt;

  assign fwft_q    = (mode_q == tcf_pkg::MODE_FWFT);
  assign mem_empty = (rgray == wgray_sync);
  assign raddr     = rbin[AW-1:0];

  // A fetch from storage: on request in standard mode, whenever the
  // output register is free or being consumed in fall-through mode.
  assign pop = !rewind && !mem_empty && (fwft_q ? (!out_valid || rd_en) : rd_en);
  assign rbin_nxt = rewind ? mark_ptr : (rbin + PW'(pop));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rbin      <= '0;
      rgray     <= '0;
      mark_ptr  <= '0;
      rd_data   <= '0;
      out_valid <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= PW'(tcf_pkg::b2g(32'(rbin_nxt)));
      if (mark) mark_ptr <= rbin;
      if (pop)  rd_data  <= mem_q;
      if (!fwft_q || rewind) out_valid <= 1'b0;
      else if (pop)          out_valid <= 1'b1;
      else if (rd_en)        out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= tcf_pkg::rd_mode_e'(fwft_sel);
  end

  assign flag_ef_or = fwft_q ? out_valid : mem_empty;
endmodule

// File: rtl/twin_clock_fifo.sv
module twin_clock_fifo #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          mark,
  input  logic          rewind,
  output logic          flag_ef_or,
  output logic          flag_ff_ir,
  output logic          half_full
);
  logic          rst_any;
  logic [AW:0]   wr_bin, wr_gray, wr_level, wr_gray_at_rd;
  logic [AW:0]   rd_ptr_bin, rd_gray, rd_gray_at_wr, mark_ptr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] mem_q;
  logic          push_evt, pop_evt, fwft_rd;

  assign rst_any = mrst | prst;

  tcf_sync2 #(.W(AW + 1)) u_sync_w2r (
    .clk(rd_clk), .rst(rst_any), .d(wr_gray), .q(wr_gray_at_rd)
  );

  tcf_sync2 #(.W(AW + 1)) u_sync_r2w (
    .clk(wr_clk), .rst(rst_any), .d(rd_gray), .q(rd_gray_at_wr)
  );

  tcf_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(rst_any), .mrst(mrst), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .rgray_sync(rd_gray_at_wr),
    .wbin(wr_bin), .wgray(wr_gray), .level(wr_level), .push(push_evt),
    .flag_ff_ir(flag_ff_ir), .half_full(half_full)
  );

  tcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(push_evt), .waddr(wr_bin[AW-1:0]), .wdata(wr_data),
    .raddr(rd_addr), .rdata(mem_q)
  );

  tcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .clk(rd_clk), .rst(rst_any), .mrst(mrst), .fwft_sel(fwft_sel),
    .rd_en(rd_en), .mark(mark), .rewind(rewind),
    .wgray_sync(wr_gray_at_rd), .mem_q(mem_q),
    .raddr(rd_addr), .rbin(rd_ptr_bin), .rgray(rd_gray), .mark_ptr(mark_ptr),
    .rd_data(rd_data), .flag_ef_or(flag_ef_or), .fwft_q(fwft_rd), .pop(pop_evt)
  );
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_any,
  input logic          mrst,
  input logic          rd_en,
  input logic          rewind,
  input logic          fwft_rd,
  input logic          flag_ef_or,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wr_gray,
  input logic [AW:0]   rd_gray,
  input logic [AW:0]   wr_level,
  input logic [AW:0]   rd_ptr_bin,
  input logic [AW:0]   mark_ptr
);
  localparam int DEPTH = 1 << AW;

  // R8: write position moves one Gray bit at most per write clock
  p_wr_gray_step_r8: assert property (@(posedge wr_clk) disable iff (rst_any)
    1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

  // R8: read position moves one Gray bit at most unless rewound
  p_rd_gray_step_r8: assert property (@(posedge rd_clk) disable iff (rst_any)
    !rewind |=> ($countones(rd_gray ^ $past(rd_gray)) <= 1));

  // R7: occupancy seen by the writer never exceeds the storage
  p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (rst_any)
    wr_level <= (AW + 1)'(DEPTH));

  // R3: standard-mode output holds without a read request
  p_std_hold_r3: assert property (@(posedge rd_clk) disable iff (rst_any)
    (!fwft_rd && !rd_en) |=> $stable(rd_data));

  // R4: a ready fall-through word holds until consumed
  p_fwft_hold_r4: assert property (@(posedge rd_clk) disable iff (rst_any)
    (fwft_rd && flag_ef_or && !rd_en && !rewind) |=> (flag_ef_or && $stable(rd_data)));

  // R10: rewind loads exactly the saved position
  p_rewind_load_r10: assert property (@(posedge rd_clk) disable iff (rst_any)
    rewind |=> (rd_ptr_bin == $past(mark_ptr)));

  // R2: mode does not change outside master reset
  p_mode_static_r2: assert property (@(posedge rd_clk) disable iff (mrst)
    1'b1 |=> $stable(fwft_rd));
endmodule

bind twin_clock_fifo tcf_checker #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_any(rst_any), .mrst(mrst),
  .rd_en(rd_en), .rewind(rewind), .fwft_rd(fwft_rd), .flag_ef_or(flag_ef_or),
  .rd_data(rd_data), .wr_gray(wr_gray), .rd_gray(rd_gray), .wr_level(wr_level),
  .rd_ptr_bin(rd_ptr_bin), .mark_ptr(mark_ptr)
);

// File: tb/twin_clock_fifo_tb_top.sv
module twin_clock_fifo_tb_top;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  // One time unit stands for 100 ps: write clock period 50 (200 MHz),
  // read clock period 80 with an offset so no edges coincide.
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, mrst = 1'b1, prst = 1'b0;
  logic fwft_sel = 1'b0, mark = 1'b0, rewind = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic flag_ef_or, flag_ff_ir, half_full;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [DW-1:0] last, v;

  initial forever #25 wr_clk = ~wr_clk;
  initial begin #3; forever #40 rd_clk = ~rd_clk; end

  twin_clock_fifo #(.DW(DW), .AW(AW)) dut_i (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
    .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .mark(mark), .rewind(rewind),
    .flag_ef_or(flag_ef_or), .flag_ff_ir(flag_ff_ir), .half_full(half_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic do_mrst(input logic mode);
    @(negedge wr_clk);
    mrst = 1'b1; fwft_sel = mode;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    mrst = 1'b0;
    settle();
  endtask

  task automatic do_prst();
    @(negedge wr_clk);
    prst = 1'b1;
    repeat (3) @(negedge rd_clk);
    @(negedge wr_clk);
    prst = 1'b0;
    settle();
  endtask

  task automatic wr1(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd1(output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_mark();
    @(negedge rd_clk); mark = 1'b1;
    @(negedge rd_clk); mark = 1'b0;
  endtask

  task automatic pulse_rewind();
    @(negedge rd_clk); rewind = 1'b1;
    @(negedge rd_clk); rewind = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // ---------------- standard mode ----------------
    do_mrst(1'b0);
    chk("R1 std reset ef", 32'(flag_ef_or), 1);
    chk("R1 std reset ff", 32'(flag_ff_ir), 0);
    chk("R1 std reset hf", 32'(half_full), 0);
    chk("R1 std reset data", 32'(rd_data), 0);
    fwft_sel = 1'b1;  // R2: outside master reset, must not switch mode
    last = '0;

    for (int k = 0; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) wr1(DW'(k * 16 + i));
      if (k == DEPTH) wr1(8'hEE);  // R7 overflow attempt
      settle();
      chk($sformatf("R5 std ef level %0d", k), 32'(flag_ef_or), 32'(k == 0));
      chk($sformatf("R5 std ff level %0d", k), 32'(flag_ff_ir), 32'(k == DEPTH));
      chk($sformatf("R6 hf level %0d", k), 32'(half_full), 32'(k > HALF));
      chk($sformatf("R3 R2 hold before read level %0d", k), 32'(rd_data), 32'(last));
      for (int i = 0; i < k; i++) begin
        rd1(v);
        chk($sformatf("R8 order level %0d idx %0d", k, i), 32'(v), 32'(k * 16 + i));
        last = v;
      end
      rd1(v);  // R7 underflow attempt
      chk($sformatf("R7 underflow ignored level %0d", k), 32'(v), 32'(last));
      settle();
      chk($sformatf("R7 empty after drain level %0d", k), 32'(flag_ef_or), 1);
      chk($sformatf("R6 hf clear after drain %0d", k), 32'(half_full), 0);
    end

    // ---------------- mark / rewind, standard ----------------
    do_mrst(1'b0);
    for (int i = 0; i < 6; i++) wr1(DW'(8'h40 + i));
    settle();
    rd1(v); rd1(v);
    pulse_mark();
    for (int i = 2; i < 6; i++) begin
      rd1(v);
      chk("R8 pre-mark read", 32'(v), 32'(8'h40 + i));
    end
    settle();
    chk("R12 empty before rewind", 32'(flag_ef_or), 1);
    pulse_rewind();
    settle();
    chk("R12 not empty after rewind", 32'(flag_ef_or), 0);
    for (int i = 2; i < 6; i++) begin
      rd1(v);
      chk("R10 replay from mark", 32'(v), 32'(8'h40 + i));
    end

    // R11: rewind with no mark since partial reset
    do_prst();
    chk("R9 std prst ef", 32'(flag_ef_or), 1);
    for (int i = 0; i < 3; i++) wr1(DW'(8'h60 + i));
    settle();
    for (int i = 0; i < 3; i++) rd1(v);
    chk("R8 last of three", 32'(v), 32'h62);
    pulse_rewind();
    settle();
    for (int i = 0; i < 3; i++) begin
      rd1(v);
      chk("R11 replay from first location", 32'(v), 32'(8'h60 + i));
    end
    // R10: read in the rewind cycle is ignored
    @(negedge rd_clk); rewind = 1'b1; rd_en = 1'b1;
    @(negedge rd_clk); rewind = 1'b0; rd_en = 1'b0;
    chk("R10 read ignored during rewind", 32'(rd_data), 32'h62);
    settle();
    rd1(v);
    chk("R10 first word after rewind", 32'(v), 32'h60);

    // ---------------- fall-through mode ----------------
    do_mrst(1'b1);
    fwft_sel = 1'b0;  // R2: ignored outside master reset
    chk("R1 fwft reset or", 32'(flag_ef_or), 0);
    chk("R1 fwft reset ir", 32'(flag_ff_ir), 1);
    chk("R1 fwft reset hf", 32'(half_full), 0);
    wr1(8'hA1);
    settle();
    chk("R4 first word falls through", 32'(rd_data), 32'hA1);
    chk("R4 output ready", 32'(flag_ef_or), 1);
    wr1(8'hA2); wr1(8'hA3);
    settle();
    chk("R4 word held without read", 32'(rd_data), 32'hA1);
    rd1(v);
    chk("R4 next after read", 32'(v), 32'hA2);
    rd1(v);
    chk("R4 third after read", 32'(v), 32'hA3);
    rd1(v);
    chk("R5 output ready drops", 32'(flag_ef_or), 0);
    rd1(v);
    chk("R7 fwft underflow data", 32'(v), 32'hA3);
    chk("R7 fwft underflow or", 32'(flag_ef_or), 0);

    // R5: capacity of storage plus output register
    wr1(8'hB0);
    settle();
    for (int i = 1; i <= DEPTH; i++) wr1(DW'(8'hB0 + i));
    wr1(8'hEE);
    settle();
    chk("R5 fwft input not ready", 32'(flag_ff_ir), 0);
    chk("R6 fwft hf", 32'(half_full), 1);
    for (int i = 1; i <= DEPTH; i++) begin
      rd1(v);
      chk("R8 fwft order", 32'(v), 32'(8'hB0 + i));
    end
    rd1(v);
    chk("R7 fwft overflow dropped", 32'(flag_ef_or), 0);
    settle();
    chk("R5 fwft input ready again", 32'(flag_ff_ir), 1);

    // R9: partial reset keeps fall-through mode
    wr1(8'hC1); wr1(8'hC2);
    fwft_sel = 1'b0;
    do_prst();
    chk("R9 fwft prst or", 32'(flag_ef_or), 0);
    chk("R9 fwft prst ir", 32'(flag_ff_ir), 1);
    chk("R9 fwft prst data", 32'(rd_data), 0);
    wr1(8'hD4);
    settle();
    chk("R9 mode kept after prst", 32'(rd_data), 32'hD4);
    chk("R9 mode kept or", 32'(flag_ef_or), 1);

    finish_run();
  end
endmodule